// File: doc/BRIEF.md
# Event Record Reader (Host Side)

This block is the host end of a two-wire synchronous link to a remote decoder. The host owns the clock line; the device owns the data line. When the device has a record ready, it raises the data line. The reader answers by driving the clock high and waits for the device to drop the data line. It then toggles the clock to pull in a chosen number of record bits. Bits arrive least significant first.

The captured bits are split into status flags, a function code, a block index, a learned-count field and a 64-bit payload. These are presented in parallel together with a one-cycle strobe. The reader does not need to take a whole record. It can stop after any bit count up to 80. It then holds the clock low for longer than the device's idle timeout, so the device gives up the transfer before the next request is served.

The framing bits are checked for every bit that was actually read. If the device never answers the acknowledge, the reader gives up and reports an error.

Top module: `evrec_reader`

## Requirements
- R1: After reset, the clock output is low and neither strobe is active. No request is served until the clock has been held low for IDLE_GAP cycles after reset.
- R2: In the idle state, a high data line is a request. The reader drives the clock high and keeps it high, with no bit clocking, until the synchronized data line reads low.
- R3: During a read, each clock low phase lasts HALF_LO cycles and each high phase lasts HALF_HI cycles. This includes the first low phase after the acknowledge. The data line is sampled in the last high cycle before each falling edge.
- R4: Record bit k is the k-th bit sampled. The field positions are:
  - bit 0: start
  - bit 1: repeat flag
  - bit 2: low-voltage flag
  - bits 6:3: function
  - bit 7: stop
  - bits 11:8: block
  - bits 15:12: count
  - bits 79:16: payload
- R5: Exactly min(req_len, 80) clock high pulses follow the acknowledge. That number is reported on rec_nbits_o. A request above 80 is clamped to 80.
- R6: Record bits that were not read are reported as zero in every field.
- R7: frame_err_o is set when at least 1 bit was read and the start bit is 1. It is also set when at least 8 bits were read and the stop bit is 0. Otherwise it is clear.
- R8: rec_valid_o is a one-cycle pulse in the cycle after the last bit is sampled, or right after the acknowledge when zero bits are requested. The clock is low during the pulse.
- R9: After a record or a timeout, the clock stays low for at least IDLE_GAP cycles before the next acknowledge.
- R10: If the data line is still high ACK_TMO cycles after the acknowledge, the clock drops and ack_err_o pulses for one cycle. No rec_valid_o pulse follows for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_len | input | 7 | Number of record bits to read, latched at the request |
| sdat_i | input | 1 | Data line from the device (asynchronous) |
| sclk_o | output | 1 | Link clock driven by the host |
| rec_valid_o | output | 1 | One-cycle strobe: record fields are valid |
| rec_rpt_o | output | 1 | Repeat flag |
| rec_lowv_o | output | 1 | Low-voltage flag |
| rec_func_o | output | 4 | Function code |
| rec_block_o | output | 4 | Block index |
| rec_count_o | output | 4 | Learned-count field |
| rec_payload_o | output | 64 | Decrypted payload bits |
| rec_nbits_o | output | 7 | Bits actually read |
| frame_err_o | output | 1 | Start/stop framing error, valid with rec_valid_o |
| ack_err_o | output | 1 | One-cycle pulse on acknowledge timeout |

## Verification
The assertions assume a device that changes the data line only shortly after a rising clock edge, holds it through the high phase, and releases the line low within IDLE_GAP cycles once the clock stops. Together with HALF_HI above the synchronizer depth, this means a sampled bit is always settled. The bench device model acts only on clock-line edges. It waits 2 ns after each edge before driving the data line, releases the line after a fixed low-time timeout shorter than IDLE_GAP, and varies only the acknowledge delay, the record contents and the requested length.

// File: rtl/evrec_pkg.sv
`timescale 1ns/1ps
// Package evrec_pkg
// Shared sizes, bit positions of the record fields, the sequencer state
// type and the unpacked field structure used by the event record reader.
package evrec_pkg;

    localparam int REC_BITS = 80;
    localparam int CNT_W    = $clog2(REC_BITS + 1);
    localparam int FUNC_W   = 4;
    localparam int BLK_W    = 4;
    localparam int LCNT_W   = 4;
    localparam int PAY_W    = 64;

    // Bit positions inside the serial record (order is behaviour)
    localparam int POS_START = 0;
    localparam int POS_RPT   = 1;
    localparam int POS_LOWV  = 2;
    localparam int POS_FUNC  = 3;
    localparam int POS_STOP  = POS_FUNC + FUNC_W;
    localparam int POS_BLK   = POS_STOP + 1;
    localparam int POS_LCNT  = POS_BLK + BLK_W;
    localparam int POS_PAY   = POS_LCNT + LCNT_W;

    typedef enum logic [2:0] {
        ST_GAP,
        ST_IDLE,
        ST_ACK,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } rd_state_t;

    typedef struct packed {
        logic              start;
        logic              rpt;
        logic              lowv;
        logic [FUNC_W-1:0] func;
        logic              stop;
        logic [BLK_W-1:0]  block;
        logic [LCNT_W-1:0] count;
        logic [PAY_W-1:0]  payload;
    } rec_fields_t;

endpackage

// File: rtl/evrec_sync.sv
`timescale 1ns/1ps
// Module evrec_sync
// Multi-stage synchronizer that brings the asynchronous data line into
// the system clock domain.
// Assumes: the input is a level that stays stable for several cycles.
module evrec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/evrec_seq.sv
`timescale 1ns/1ps
// Module evrec_seq
// Link sequencer. It holds the clock low for the idle gap, answers a
// request with the clock high, waits for the data line to drop and then
// makes the bit clock pulses. It issues one capture per bit, just before
// each falling edge.
// Assumes: line_hi is already synchronized; HALF_HI is larger than the
// synchronizer depth.
module evrec_seq
    import evrec_pkg::*;
#(
    parameter int HALF_HI  = 25,
    parameter int HALF_LO  = 25,
    parameter int ACK_TMO  = 25000,
    parameter int IDLE_GAP = 60000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_hi,
    input  logic [CNT_W-1:0] req_len,
    output logic             sclk_o,
    output logic             cap_clr_o,
    output logic             cap_en_o,
    output logic [CNT_W-1:0] cap_idx_o,
    output logic             done_o,
    output logic             ack_err_o,
    output logic [CNT_W-1:0] nbits_o
);

    localparam int T_A  = (HALF_HI > HALF_LO) ? HALF_HI : HALF_LO;
    localparam int T_B  = (ACK_TMO > IDLE_GAP) ? ACK_TMO : IDLE_GAP;
    localparam int TMAX = (T_A > T_B) ? T_A : T_B;
    localparam int TW   = $clog2(TMAX + 1);

    rd_state_t        st, st_nx;
    logic [TW-1:0]    tmr;
    logic [TW-1:0]    lim;
    logic             tmr_end;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] len_clamped;
    logic             sclk_q;
    logic             aerr_q;

    // Clamp the requested bit count to the record length
    always_comb begin
        if (req_len > CNT_W'(REC_BITS)) begin
            len_clamped = CNT_W'(REC_BITS);
        end else begin
            len_clamped = req_len;
        end
    end

    // Select the phase length for the current state
    always_comb begin
        unique case (st)
            ST_GAP:  lim = TW'(IDLE_GAP - 1);
            ST_ACK:  lim = TW'(ACK_TMO - 1);
            ST_LOW:  lim = TW'(HALF_LO - 1);
            ST_HIGH: lim = TW'(HALF_HI - 1);
            default: lim = '0;
        endcase
        tmr_end = (tmr == lim);
    end

    // Next-state decision
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_GAP:  if (tmr_end) st_nx = ST_IDLE;
            ST_IDLE: if (line_hi) st_nx = ST_ACK;
            ST_ACK: begin
                if (!line_hi) begin
                    st_nx = (len_q == '0) ? ST_DONE : ST_LOW;
                end else if (tmr_end) begin
                    st_nx = ST_GAP;
                end
            end
            ST_LOW:  if (tmr_end) st_nx = ST_HIGH;
            ST_HIGH: begin
                if (tmr_end) begin
                    st_nx = (idx_q == len_q - 1'b1) ? ST_DONE : ST_LOW;
                end
            end
            ST_DONE: st_nx = ST_GAP;
            default: st_nx = ST_GAP;
        endcase
    end

    // State, phase timer and clock register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_GAP;
            tmr    <= '0;
            sclk_q <= 1'b0;
        end else begin
            st     <= st_nx;
            sclk_q <= (st_nx == ST_ACK) || (st_nx == ST_HIGH);
            if ((st_nx != st) || (st == ST_IDLE)) begin
                tmr <= '0;
            end else begin
                tmr <= tmr + 1'b1;
            end
        end
    end

    // Latch the length at the request and count the sampled bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            idx_q <= '0;
        end else if (st == ST_IDLE && line_hi) begin
            len_q <= len_clamped;
            idx_q <= '0;
        end else if (st == ST_HIGH && tmr_end) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // One-cycle acknowledge-timeout pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aerr_q <= 1'b0;
        end else begin
            aerr_q <= (st == ST_ACK) && line_hi && tmr_end;
        end
    end

    assign sclk_o    = sclk_q;
    assign cap_clr_o = (st == ST_IDLE) && line_hi;
    assign cap_en_o  = (st == ST_HIGH) && tmr_end;
    assign cap_idx_o = idx_q;
    assign done_o    = (st == ST_DONE);
    assign ack_err_o = aerr_q;
    assign nbits_o   = idx_q;

endmodule

// File: rtl/evrec_capture.sv
`timescale 1ns/1ps
// Module evrec_capture
// Record register with one flop per bit position. The register clears
// when a request is taken; after that each capture writes the sampled
// line into the indexed bit. Bits that are never written stay zero.
// Assumes: the index is below REC_BITS whenever the write enable is high.
module evrec_capture
    import evrec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                en_i,
    input  logic [CNT_W-1:0]    idx_i,
    input  logic                bit_i,
    output logic [REC_BITS-1:0] rec_o
);

    for (genvar gi = 0; gi < REC_BITS; gi++) begin : g_bit
        // Clear on a new request, load on a matching capture
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                rec_o[gi] <= 1'b0;
            end else if (en_i && (idx_i == CNT_W'(gi))) begin
                rec_o[gi] <= bit_i;
            end
        end
    end

endmodule

// File: rtl/evrec_unpack.sv
`timescale 1ns/1ps
// Module evrec_unpack
// Splits the captured record into its fields. It flags a framing error
// on a set start bit, or on a clear stop bit, counting each of these
// framing bits only when it was actually read.
// Assumes: unread record bits are zero.
module evrec_unpack
    import evrec_pkg::*;
(
    input  logic [REC_BITS-1:0] rec_i,
    input  logic [CNT_W-1:0]    nbits_i,
    output rec_fields_t         fld_o,
    output logic                frame_err_o
);

    // Field slicing by fixed position
    always_comb begin
        fld_o.start   = rec_i[POS_START];
        fld_o.rpt     = rec_i[POS_RPT];
        fld_o.lowv    = rec_i[POS_LOWV];
        fld_o.func    = rec_i[POS_FUNC +: FUNC_W];
        fld_o.stop    = rec_i[POS_STOP];
        fld_o.block   = rec_i[POS_BLK +: BLK_W];
        fld_o.count   = rec_i[POS_LCNT +: LCNT_W];
        fld_o.payload = rec_i[POS_PAY +: PAY_W];
    end

    // Framing check over the bits that were read
    always_comb begin
        frame_err_o = 1'b0;
        if ((nbits_i > CNT_W'(POS_START)) && rec_i[POS_START]) begin
            frame_err_o = 1'b1;
        end
        if ((nbits_i > CNT_W'(POS_STOP)) && !rec_i[POS_STOP]) begin
            frame_err_o = 1'b1;
        end
    end

endmodule

// File: rtl/evrec_reader.sv
`timescale 1ns/1ps
// Module evrec_reader (top)
// Host-side reader of event records over a clock/data two-wire link. It
// synchronizes the data line, runs the handshake and bit clock, captures
// the bits least significant first, and presents the unpacked fields with
// a one-cycle strobe.
// Assumes: the device updates data just after rising clock edges and
// releases the line within IDLE_GAP cycles once the clock stops.
module evrec_reader
    import evrec_pkg::*;
#(
    parameter int HALF_HI     = 25,
    parameter int HALF_LO     = 25,
    parameter int ACK_TMO     = 25000,
    parameter int IDLE_GAP    = 60000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [6:0]       req_len,
    input  logic             sdat_i,
    output logic             sclk_o,
    output logic             rec_valid_o,
    output logic             rec_rpt_o,
    output logic             rec_lowv_o,
    output logic [3:0]       rec_func_o,
    output logic [3:0]       rec_block_o,
    output logic [3:0]       rec_count_o,
    output logic [63:0]      rec_payload_o,
    output logic [6:0]       rec_nbits_o,
    output logic             frame_err_o,
    output logic             ack_err_o
);

    logic                line_hi;
    logic                cap_clr;
    logic                cap_en;
    logic [CNT_W-1:0]    cap_idx;
    logic [CNT_W-1:0]    nbits;
    logic [REC_BITS-1:0] rec;
    rec_fields_t         fld;

    evrec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sdat_i),
        .q_o   (line_hi)
    );

    evrec_seq #(
        .HALF_HI  (HALF_HI),
        .HALF_LO  (HALF_LO),
        .ACK_TMO  (ACK_TMO),
        .IDLE_GAP (IDLE_GAP)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_hi   (line_hi),
        .req_len   (req_len),
        .sclk_o    (sclk_o),
        .cap_clr_o (cap_clr),
        .cap_en_o  (cap_en),
        .cap_idx_o (cap_idx),
        .done_o    (rec_valid_o),
        .ack_err_o (ack_err_o),
        .nbits_o   (nbits)
    );

    evrec_capture u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cap_clr),
        .en_i  (cap_en),
        .idx_i (cap_idx),
        .bit_i (line_hi),
        .rec_o (rec)
    );

    evrec_unpack u_unp (
        .rec_i       (rec),
        .nbits_i     (nbits),
        .fld_o       (fld),
        .frame_err_o (frame_err_o)
    );

    assign rec_rpt_o     = fld.rpt;
    assign rec_lowv_o    = fld.lowv;
    assign rec_func_o    = fld.func;
    assign rec_block_o   = fld.block;
    assign rec_count_o   = fld.count;
    assign rec_payload_o = fld.payload;
    assign rec_nbits_o   = nbits;

endmodule

// File: rtl/evrec_chk.sv
`timescale 1ns/1ps
// Module evrec_chk
// Property checker bound to evrec_reader. It measures how long the clock
// stays low in front of each rising edge and checks strobe behaviour.
module evrec_chk #(
    parameter int HALF_LO  = 25,
    parameter int IDLE_GAP = 60000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk_o,
    input logic       rec_valid_o,
    input logic       ack_err_o,
    input logic       frame_err_o,
    input logic [6:0] rec_nbits_o
);

    int   low_run;
    logic ended;

    // Count consecutive low clock cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= 0;
        end else if (sclk_o) begin
            low_run <= 0;
        end else if (low_run < 32'h3fff_ffff) begin
            low_run <= low_run + 1;
        end
    end

    // Remember that a transfer or timeout ended before the next rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ended <= 1'b0;
        end else if (rec_valid_o || ack_err_o) begin
            ended <= 1'b1;
        end else if (sclk_o) begin
            ended <= 1'b0;
        end
    end

    p_low_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (low_run >= HALF_LO));

    p_gap_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk_o) && ended) |-> (low_run >= IDLE_GAP));

    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |=> !rec_valid_o);

    p_valid_clk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> !sclk_o);

    p_nbits_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> (rec_nbits_o <= 7'd80));

    p_err_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err_o |=> !ack_err_o);

    p_err_clk_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err_o |-> (!sclk_o && !rec_valid_o));

    p_no_frame_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_o && rec_nbits_o == 7'd0) |-> !frame_err_o);

endmodule

bind evrec_reader evrec_chk #(
    .HALF_LO  (HALF_LO),
    .IDLE_GAP (IDLE_GAP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_o      (sclk_o),
    .rec_valid_o (rec_valid_o),
    .ack_err_o   (ack_err_o),
    .frame_err_o (frame_err_o),
    .rec_nbits_o (rec_nbits_o)
);

// File: tb/sim_evrec_reader.sv
`timescale 1ns/1ps
module sim_evrec_reader;

    localparam int PER      = 20;
    localparam int HHI      = 4;
    localparam int HLO      = 3;
    localparam int ATMO     = 20;
    localparam int GAP      = 40;
    localparam int DEV_TMO  = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  req_len = '0;
    logic        sdat = 1'b0;
    logic        sclk;
    logic        valid, rpt, lowv, ferr, aerr;
    logic [3:0]  func, blk, cnt;
    logic [63:0] pay;
    logic [6:0]  nbits;

    always #(PER/2) clk = ~clk;

    evrec_reader #(
        .HALF_HI (HHI), .HALF_LO (HLO), .ACK_TMO (ATMO),
        .IDLE_GAP (GAP), .SYNC_STAGES (2)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .req_len (req_len), .sdat_i (sdat),
        .sclk_o (sclk), .rec_valid_o (valid), .rec_rpt_o (rpt),
        .rec_lowv_o (lowv), .rec_func_o (func), .rec_block_o (blk),
        .rec_count_o (cnt), .rec_payload_o (pay), .rec_nbits_o (nbits),
        .frame_err_o (ferr), .ack_err_o (aerr)
    );

    typedef struct {
        bit          is_err;
        logic        rpt, lowv;
        logic [3:0]  func, blk, cnt;
        logic [63:0] pay;
        int          nbits;
        bit          ferr;
    } exp_t;

    exp_t   sb[$];
    int     n_chk  = 0;
    int     n_fail = 0;
    longint last_fall;
    bit     prev_valid = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Driver: device model serving one record and pushing the expectation
    task automatic run_record(input logic [79:0] r, input int n, input int dly);
        int         neff;
        logic [79:0] m;
        exp_t       e;
        longint     tr, tf;
        bit         ok_t, extra;
        neff = (n > 80) ? 80 : n;
        m = '0;
        for (int i = 0; i < 80; i++) if (i < neff) m[i] = r[i];
        e.is_err = 1'b0;
        e.rpt = m[1]; e.lowv = m[2]; e.func = m[6:3];
        e.blk = m[11:8]; e.cnt = m[15:12]; e.pay = m[79:16];
        e.nbits = neff;
        e.ferr = (neff >= 1 && m[0]) || (neff >= 8 && !m[7]);
        sb.push_back(e);
        req_len = 7'(n);
        sdat = 1'b1;
        @(posedge sclk);
        tr = $time;
        chk((tr - last_fall) >= GAP * PER, "R9 idle gap before acknowledge",
            64'(tr - last_fall), 64'(GAP * PER));
        repeat (dly) @(posedge clk);
        #2;
        chk(sclk == 1'b1, "R2 clock held high until data low", 64'(sclk), 64'd1);
        sdat = 1'b0;
        ok_t = 1'b1;
        @(negedge sclk);
        tf = $time;
        for (int k = 0; k < neff; k++) begin
            @(posedge sclk);
            tr = $time;
            if (tr - tf != HLO * PER) ok_t = 1'b0;
            #2 sdat = r[k];
            @(negedge sclk);
            tf = $time;
            if (tf - tr != HHI * PER) ok_t = 1'b0;
        end
        last_fall = tf;
        extra = 1'b0;
        repeat (DEV_TMO) begin
            @(posedge clk);
            #2;
            if (sclk) extra = 1'b1;
        end
        sdat = 1'b0;
        chk(ok_t, "R3 clock phase lengths", 64'(ok_t), 64'd1);
        chk(!extra, "R5 no pulses beyond requested count", 64'(extra), 64'd0);
    endtask

    // Driver: request that is never acknowledged by the device
    task automatic run_timeout();
        exp_t   e;
        longint tr, tf;
        e = '{is_err: 1'b1, rpt: 1'b0, lowv: 1'b0, func: '0, blk: '0,
              cnt: '0, pay: '0, nbits: 0, ferr: 1'b0};
        sb.push_back(e);
        req_len = 7'd10;
        sdat = 1'b1;
        @(posedge sclk);
        tr = $time;
        chk((tr - last_fall) >= GAP * PER, "R9 idle gap before acknowledge",
            64'(tr - last_fall), 64'(GAP * PER));
        @(negedge sclk);
        tf = $time;
        chk((tf - tr) == ATMO * PER, "R10 acknowledge timeout length",
            64'(tf - tr), 64'(ATMO * PER));
        last_fall = tf;
        repeat (DEV_TMO) @(posedge clk);
        #2 sdat = 1'b0;
    endtask

    // Monitor: compare each strobe against the scoreboard head
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_valid) chk(!valid, "R8 valid is one cycle", 64'(valid), 64'd0);
                if (valid || aerr) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R8 unexpected strobe", 64'({valid, aerr}), 64'd0);
                    end else begin
                        e = sb.pop_front();
                        if (e.is_err) begin
                            chk(aerr && !valid, "R10 timeout error pulse",
                                64'({valid, aerr}), 64'b01);
                        end else begin
                            chk(valid && !aerr, "R8 record strobe", 64'({valid, aerr}), 64'b10);
                            chk(sclk == 1'b0, "R8 clock low at strobe", 64'(sclk), 64'd0);
                            chk({rpt, lowv} == {e.rpt, e.lowv}, "R4 status flags",
                                64'({rpt, lowv}), 64'({e.rpt, e.lowv}));
                            chk({func, blk, cnt} == {e.func, e.blk, e.cnt},
                                "R4 function/block/count", 64'({func, blk, cnt}),
                                64'({e.func, e.blk, e.cnt}));
                            chk(pay == e.pay, "R6 payload with unread bits zero", pay, e.pay);
                            chk(int'(nbits) == e.nbits, "R5 bits read", 64'(nbits), 64'(e.nbits));
                            chk(ferr == e.ferr, "R7 framing flag", 64'(ferr), 64'(e.ferr));
                        end
                    end
                end
            end
            prev_valid = valid;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        last_fall = $time;
        @(negedge clk);
        chk(sclk == 1'b0 && !valid && !aerr, "R1 reset state",
            64'({sclk, valid, aerr}), 64'd0);
        // R1: request raised at once, served only after the gap
        run_record({64'h0123_4567_89AB_CDEF, 4'h5, 4'hA, 1'b1, 4'h9, 1'b1, 1'b0, 1'b0}, 80, 3);
        run_record({64'hFEDC_BA98_7654_3210, 4'hF, 4'h2, 1'b1, 4'h6, 1'b0, 1'b1, 1'b0}, 100, 8);
        run_record({64'hFFFF_FFFF_FFFF_FFFF, 4'hF, 4'hF, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0}, 5, 2);
        run_record({64'hAAAA_5555_AAAA_5555, 4'h3, 4'h7, 1'b0, 4'h1, 1'b0, 1'b0, 1'b0}, 8, 4);
        run_record({64'h1111_2222_3333_4444, 4'hC, 4'h3, 1'b1, 4'hA, 1'b1, 1'b0, 1'b1}, 20, 5);
        run_record({64'hDEAD_BEEF_CAFE_F00D, 4'h1, 4'h1, 1'b1, 4'h1, 1'b1, 1'b1, 1'b1}, 0, 2);
        run_timeout();
        run_record({64'h0F0F_0F0F_0F0F_0F0F, 4'h8, 4'h4, 1'b1, 4'h2, 1'b0, 1'b1, 1'b0}, 16, 1);
        run_record({64'h8000_0000_0000_0001, 4'h9, 4'h6, 1'b1, 4'hE, 1'b1, 1'b0, 1'b0}, 79, 6);
        repeat (20) @(posedge clk);
        chk(sb.size() == 0, "R8 all records strobed", 64'(sb.size()), 64'd0);
        summary();
    end

endmodule